// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block supplies the count enables for two timer channels from one shared divider. A 10-bit counter runs on the system clock at all times. The channels' clock-select settings do not affect it. Each channel has a 3-bit select input. The select stops the channel, gives it a strobe on every cycle, picks one of four divided taps (/8, /64, /256, /1024), or passes through an edge pulse that arrives from an external synchronizer. Each channel output is a one-cycle count-enable strobe. It is not a derived clock, so the timers stay in the system clock domain.

A small control register can clear the shared divider. It also has a hold mode. While hold is set, the written reset bits stay set, so the divider stays cleared and both channels stay quiet on their internal sources. Clearing hold releases the divider, and both channels start from the same phase in the same cycle. A second reset bit belongs to a separate asynchronous timer. This block only keeps or clears that bit and exports it.

Top module: `tclk_prescale`

## Requirements
- R1: The divider adds one on every cycle in which the divider-reset bit reads 0. The select inputs never change its phase.
- R2: Select code 1 makes the channel strobe on every cycle in which the divider-reset bit reads 0, and never while it reads 1.
- R3: Select codes 2, 3, 4 and 5 pick the taps /8, /64, /256 and /1024. Each tap strobes for one cycle when the low log2(N) divider bits are all ones and the divider-reset bit reads 0.
- R4: A write with data bit 0 set makes the divider-reset bit read 1. The divider then reads zero on the following cycle. Without hold, the bit clears by itself one cycle after the write.
- R5: While the hold bit (data bit 2) reads 1, the divider-reset bit (bit 0) and the auxiliary reset bit (bit 1) keep the values last written.
- R6: A write with bit 2 clear releases hold and clears bits 0 and 1 (unless that same write sets them). A tap of divisor N then first strobes exactly N cycles after the releasing write, on both channels together.
- R7: Select code 6 copies the falling-edge pulse input, and code 7 copies the rising-edge pulse input, in the same cycle and without division.
- R8: Select code 0 gives no strobe. The read port shows {5'b0, hold, aux, reset}. After reset every register reads zero.
- R9: The auxiliary reset bit has no effect on the divider or on any strobe. It only appears on its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read value |
| aux_rst_o | output | 1 | Held auxiliary prescaler reset for the asynchronous timer |
| sel_i | input | 6 | Clock select, 3 bits per channel, channel 0 in the low bits |
| ext_rise_i | input | 2 | Per-channel rising-edge pulse from the external synchronizer |
| ext_fall_i | input | 2 | Per-channel falling-edge pulse from the external synchronizer |
| cnt_en_o | output | 2 | Per-channel one-cycle count enable |

## Verification
The hardest case to reach is a synchronized start. Hold must be set while the divider is cleared, the two channels must be set to different wide taps, and the release must then be observed as first strobes at exactly 64 and 1024 cycles. Random writes almost never produce this, so a directed sequence sets it up. A long random run with rare register writes and frequent select changes then compares every strobe against a bench model of the divider phase. The random run also covers the /1024 tap across many wraps.

// File: rtl/tclk_prescale_pkg.sv
package tclk_prescale_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NTAP  = 4;

  localparam int unsigned CTL_RST_BIT  = 0;
  localparam int unsigned CTL_AUX_BIT  = 1;
  localparam int unsigned CTL_HOLD_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF      = 3'd0,
    SEL_DIRECT   = 3'd1,
    SEL_TAP0     = 3'd2,
    SEL_TAP1     = 3'd3,
    SEL_TAP2     = 3'd4,
    SEL_TAP3     = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } clk_sel_e;

  // log2 of the divisor of each tap, in tap order
  function automatic int unsigned tap_log2(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tclk_ctl_reg.sv
module tclk_ctl_reg
  import tclk_prescale_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              div_rst_o,
  output logic              aux_rst_o
);
  logic hold_q, hold_d;
  logic rst_q, rst_d;
  logic aux_q, aux_d;

  always_comb begin
    hold_d = hold_q;
    rst_d  = hold_q ? rst_q : 1'b0;
    aux_d  = hold_q ? aux_q : 1'b0;
    if (wr_i) begin
      hold_d = wdata_i[CTL_HOLD_BIT];
      rst_d  = wdata_i[CTL_RST_BIT];
      aux_d  = wdata_i[CTL_AUX_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rst_q  <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rst_q  <= rst_d;
      aux_q  <= aux_d;
    end
  end

  always_comb begin
    rdata_o               = '0;
    rdata_o[CTL_HOLD_BIT] = hold_q;
    rdata_o[CTL_AUX_BIT]  = aux_q;
    rdata_o[CTL_RST_BIT]  = rst_q;
  end

  assign div_rst_o = rst_q;
  assign aux_rst_o = aux_q;

  // R4: without hold and without a write, the reset bit is gone next cycle
  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !wr_i) |=> (!div_rst_o && !aux_rst_o));

  // R5: hold keeps both reset bits as written
  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_i) |=> ($stable(div_rst_o) && $stable(aux_rst_o)));

  // R8: bits outside the three control bits never read as one
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rdata_o) <= 3 && rdata_o[DATA_W-1:CTL_HOLD_BIT+1] == '0);
endmodule

// File: rtl/tclk_div.sv
module tclk_div
  import tclk_prescale_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  output logic            run_o,
  output logic [NTAP-1:0] tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run_o = !clr_i;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int unsigned LW = tap_log2(g);
    assign tick_o[g] = !clr_i && (&cnt_q[LW-1:0]);
    if (g > 0) begin : g_nest
      // R3: a wider tap only fires on a cycle where every narrower tap fires
      a_r3_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[g] |-> tick_o[g-1]);
    end
  end

  // R4: a held divider reset leaves the counter at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R1: free run by one per cycle
  a_r1_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == DIV_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tclk_chan_sel.sv
module tclk_chan_sel
  import tclk_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic [NTAP-1:0]  tick_i,
  input  logic             ext_rise_i,
  input  logic             ext_fall_i,
  output logic             en_o
);
  clk_sel_e sel;
  assign sel = clk_sel_e'(sel_i);

  always_comb begin
    case (sel)
      SEL_OFF:      en_o = 1'b0;
      SEL_DIRECT:   en_o = run_i;
      SEL_TAP0:     en_o = tick_i[0];
      SEL_TAP1:     en_o = tick_i[1];
      SEL_TAP2:     en_o = tick_i[2];
      SEL_TAP3:     en_o = tick_i[3];
      SEL_EXT_FALL: en_o = ext_fall_i;
      SEL_EXT_RISE: en_o = ext_rise_i;
      default:      en_o = 1'b0;
    endcase
  end

  // R8: a stopped channel never strobes
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd0) |-> !en_o);

  // R7: external edges pass undivided
  a_r7_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd7) |-> (en_o == ext_rise_i));

  // R2: direct select strobes whenever any tap strobes
  a_r2_direct_covers: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == 3'd1) && (tick_i[0])) |-> en_o);
endmodule

// File: rtl/tclk_prescale.sv
module tclk_prescale
  import tclk_prescale_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr_i,
  input  logic [DATA_W-1:0]    ctl_wdata_i,
  output logic [DATA_W-1:0]    ctl_rdata_o,
  output logic                 aux_rst_o,
  input  logic [NCH*SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]       ext_rise_i,
  input  logic [NCH-1:0]       ext_fall_i,
  output logic [NCH-1:0]       cnt_en_o
);
  logic            div_rst;
  logic            run;
  logic [NTAP-1:0] tick;

  tclk_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctl_wr_i),
    .wdata_i   (ctl_wdata_i),
    .rdata_o   (ctl_rdata_o),
    .div_rst_o (div_rst),
    .aux_rst_o (aux_rst_o)
  );

  tclk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (div_rst),
    .run_o  (run),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tclk_chan_sel u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (sel_i[c*SEL_W +: SEL_W]),
      .run_i      (run),
      .tick_i     (tick),
      .ext_rise_i (ext_rise_i[c]),
      .ext_fall_i (ext_fall_i[c]),
      .en_o       (cnt_en_o[c])
    );
  end

  // R6: while the divider is held cleared no internal source strobes on any channel
  a_r6_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> (tick == '0 && !run));
endmodule

// File: tb/tclk_prescale_test.sv
module tclk_prescale_test;
  localparam int NCH = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       aux_rst;
  logic [5:0] sel;
  logic [1:0] ext_rise, ext_fall;
  logic [1:0] cnt_en;

  int n_vec  = 0;
  int n_fail = 0;

  // bench model state
  logic [9:0] m_cnt;
  logic       m_rst, m_aux, m_hold;
  logic [1:0] last_en;

  tclk_prescale uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .aux_rst_o(aux_rst), .sel_i(sel),
    .ext_rise_i(ext_rise), .ext_fall_i(ext_fall), .cnt_en_o(cnt_en)
  );

  always #10 clk = ~clk;

  function automatic logic exp_en(input logic [2:0] s, input logic r, input logic f);
    case (s)
      3'd0: return 1'b0;
      3'd1: return !m_rst;
      3'd2: return !m_rst && (m_cnt[2:0] == 3'h7);
      3'd3: return !m_rst && (m_cnt[5:0] == 6'h3f);
      3'd4: return !m_rst && (m_cnt[7:0] == 8'hff);
      3'd5: return !m_rst && (m_cnt == 10'h3ff);
      3'd6: return f;
      default: return r;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R8";
      3'd1: return "R2";
      3'd6, 3'd7: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs already driven; compare, then advance the model over one edge
  task automatic run_cycle();
    #2;
    for (int c = 0; c < NCH; c++) begin
      check(req_of(sel[c*3 +: 3]), {7'b0, cnt_en[c]},
            {7'b0, exp_en(sel[c*3 +: 3], ext_rise[c], ext_fall[c])});
    end
    // R5 R8 R9: register readback and exported auxiliary bit
    check("R5", ctl_rdata, {5'b0, m_hold, m_aux, m_rst});
    check("R9", {7'b0, aux_rst}, {7'b0, m_aux});
    last_en = cnt_en;
    @(posedge clk);
    m_cnt = m_rst ? 10'd0 : m_cnt + 10'd1;
    if (ctl_wr) begin
      m_hold = ctl_wdata[2];
      m_rst  = ctl_wdata[0];
      m_aux  = ctl_wdata[1];
    end else if (!m_hold) begin
      m_rst = 1'b0;
      m_aux = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    run_cycle();
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int first0, first1;
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00;
    sel = 6'h00; ext_rise = 2'b00; ext_fall = 2'b00;
    m_cnt = 10'd0; m_rst = 1'b0; m_aux = 1'b0; m_hold = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    // R8: reset state
    check("R8", ctl_rdata, 8'h00);
    check("R8", {6'b0, cnt_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 and R3 directed: direct on channel 0, /8 on channel 1
    sel = {3'd2, 3'd1};
    repeat (20) run_cycle();

    // R4: one-shot divider reset, then self-clear
    write_ctl(8'h01);
    check("R4", ctl_rdata, 8'h01);
    run_cycle();
    check("R4", ctl_rdata, 8'h00);

    // R9: auxiliary bit alone leaves the phase untouched (model keeps counting)
    sel = {3'd3, 3'd2};
    write_ctl(8'h02);
    repeat (70) run_cycle();

    // R5 R6: hold with divider cleared, then release; first strobes at 64 and 1024
    write_ctl(8'h05);
    sel = {3'd5, 3'd3};
    repeat (30) run_cycle();
    check("R5", ctl_rdata, 8'h05);
    check("R6", {6'b0, cnt_en}, 8'h00);
    write_ctl(8'h00);
    first0 = 0; first1 = 0;
    for (int k = 1; k <= 1100; k++) begin
      run_cycle();
      if (last_en[0] && first0 == 0) first0 = k;
      if (last_en[1] && first1 == 0) first1 = k;
    end
    check("R6", 8'(first0), 8'(64));
    check("R6", {6'b0, first1[9:8]}, 8'h00);
    check("R6", first1[7:0], 8'h00);
    n_vec++;
    if (first1 != 1024) begin
      n_fail++;
      $display("FAIL R6: actual %0d expected 1024", first1);
    end

    // R7: external pulses while hold keeps the divider cleared
    write_ctl(8'h07);
    sel = {3'd7, 3'd6};
    for (int k = 0; k < 40; k++) begin
      ext_rise = 2'($urandom % 4); ext_fall = 2'($urandom % 4);
      run_cycle();
    end
    write_ctl(8'h00);

    // R1 R3: long random run
    for (int k = 0; k < 30000; k++) begin
      if ($urandom % 40 == 0) sel = 6'($urandom);
      ext_rise = 2'($urandom % 4);
      ext_fall = 2'($urandom % 4);
      if ($urandom % 300 == 0) begin
        logic [7:0] d;
        d = 8'($urandom % 8);
        if ($urandom % 2 == 0) d[2] = 1'b0;
        write_ctl(d);
      end else begin
        run_cycle();
      end
    end
    write_ctl(8'h00);
    repeat (5) run_cycle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule